// File: doc/BRIEF.md
# Receive Character Queue with Fill-Level Interrupt

This block holds characters that a serial receiver has finished assembling until the host collects them. Each character arrives on a one-cycle write strobe. It enters a first-in first-out store of 64 bytes. The host pops characters with a one-cycle read strobe, and the popped byte appears on a registered read-data output.

The block compares the fill count with one of four selectable thresholds and drives a level interrupt from the result. A two-bit source code reports the same condition. Both signals follow the fill count up and down, so the host never acknowledges them. A separate data-ready flag shows that at least one character is waiting, whatever the threshold. When queueing is switched off, the store keeps at most one character and acts as a single holding register.

The write side cannot be stalled, because the receiver has no way to hold a finished character. So the write port has a valid strobe and no ready. A character that arrives when no space is free is discarded, and a sticky overrun flag records the loss. On the read side, the data-ready flag is the valid indication and the read strobe is the ready. A strobe given while the store is empty is harmless.

Top module: `rxq_trig_buf`

## Requirements
- R1: While `rst_n` is low and just after reset, `data_rdy`, `irq` and `overrun` are 0, `src_code` is 2'b00 and `rd_data` is 8'h00.
- R2: Characters are read out in the order they were accepted. A read strobe sampled at a rising edge, with the store non-empty, places the oldest character on `rd_data` at that edge, and `rd_data` holds it until the next successful read.
- R3: With `q_en`=1 the store holds 64 characters. A write that arrives while the store is full and no read is given in that cycle is discarded, and `overrun` becomes 1 at the same edge. `overrun` stays 1 until `ovr_clr` is sampled high. If a new loss and `ovr_clr` come in the same cycle, the loss wins.
- R4: `data_rdy` is 1 from the edge that accepts a character until the edge at which the store becomes empty.
- R5: `lvl_sel` picks the threshold: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 56 characters. With `q_en`=1 and `rx_ie`=1, `irq` is 1 whenever the fill count is at or above the selected threshold.
- R6: `irq` returns to 0 as soon as the fill count drops below the threshold. No acknowledge is needed.
- R7: `src_code` is 2'b01 (receive data available) exactly while `irq` is 1, and 2'b00 otherwise.
- R8: With `rx_ie`=0, `irq` is 0 and `src_code` is 2'b00, whatever the fill count.
- R9: A read strobe while the store is empty leaves `rd_data` unchanged and the store empty.
- R10: A write and a read in the same cycle on a non-empty store leave the fill count unchanged, even when the store is full. The written character is kept.
- R11: With `q_en`=0 the store keeps at most one character. `irq` is 1 while that character is present and `rx_ie`=1. A second write before a read is discarded and sets `overrun`.
- R12: A change of `q_en` empties the store at the first edge that samples the new value. Any write in that cycle is dropped without setting `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Character from the receiver is present (no back-pressure) |
| wr_data | input | 8 | Received character |
| rd_req | input | 1 | Host pop strobe |
| rd_data | output | 8 | Last character popped by the host |
| q_en | input | 1 | 1 = 64-deep queue, 0 = single holding register |
| rx_ie | input | 1 | Receive interrupt enable |
| lvl_sel | input | 2 | Threshold select (1, 16, 32, 56) |
| ovr_clr | input | 1 | Clears the overrun flag |
| irq | output | 1 | Receive-data-available interrupt, level |
| src_code | output | 2 | Interrupt source field, 2'b01 = data available |
| data_rdy | output | 1 | At least one character is waiting |
| overrun | output | 1 | Sticky flag for a lost character |

## Verification
Every strobe takes effect at the rising edge that samples it. The fill count, `rd_data`, `data_rdy` and `overrun` therefore change one edge after the stimulus. `irq` and `src_code` are combinational from the registered count, so they follow that same edge. They also follow `rx_ie` and `lvl_sel` at once, with no edge needed. The bench changes inputs at a falling edge and reads the outputs at the next falling edge. Each check therefore sees exactly one rising edge after its stimulus, and it sees the enable and select values already settled.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Interrupt source field values
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_RDA  = 2'b01
  } rx_src_e;

  // Next pointer value for a circular index over 'depth' slots
  function automatic int unsigned ring_next(int unsigned cur, int unsigned depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cap_one,
  input  logic             push_req,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     rd_data,
  output logic             dropped
);
  import rxq_pkg::*;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic             full, empty, pop, push;

  assign empty = (cnt == '0);
  assign full  = cap_one ? !empty : (cnt == CNT_W'(DEPTH));
  assign pop   = pop_req && !empty && !flush;
  assign push  = push_req && !flush && (!full || pop);
  assign dropped = push_req && !flush && !push;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
    end else begin : g_ring
      assign wptr_nx = PTR_W'(ring_next(32'(wptr), DEPTH));
      assign rptr_nx = PTR_W'(ring_next(32'(rptr), DEPTH));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr_nx;
      if (pop) begin
        rptr    <= rptr_nx;
        rd_data <= mem[rptr];
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: popping an empty store leaves the output byte alone
  p_empty_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !flush) |=> $stable(rd_data));

  // R10: simultaneous push and pop on a non-empty store keeps the count
  p_simul_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !empty && !flush) |=> $stable(cnt));

  // R11: holding-register mode never keeps more than one character
  p_hold_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_one && !flush) |-> (cnt <= CNT_W'(1)));

  // R3: count never exceeds the queue depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/rxq_trig_eval.sv
module rxq_trig_eval #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 16,
  parameter int unsigned LVL2  = 32,
  parameter int unsigned LVL3  = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             queue_mode,
  input  logic             ie,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic [1:0]       src
);
  import rxq_pkg::*;

  localparam int unsigned LVLS [4] = '{LVL0, LVL1, LVL2, LVL3};

  logic [31:0] fill32, thresh;
  logic        reached;
  rx_src_e     src_e;

  assign fill32 = 32'(cnt);
  assign thresh = queue_mode ? LVLS[sel] : 32'd1;
  assign reached = (fill32 >= thresh);
  assign irq = ie && reached;

  always_comb begin
    src_e = SRC_NONE;
    if (irq) src_e = SRC_RDA;
  end
  assign src = src_e;

  // R8: no interrupt while the enable is off
  p_ie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> (!irq && src == 2'b00));

  // R6: a falling interrupt with steady controls needs a smaller count
  p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq) && $stable(ie) && $stable(sel) && $stable(queue_mode))
      |-> (cnt < $past(cnt)));

endmodule

// File: rtl/rxq_trig_buf.sv
module rxq_trig_buf #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 16,
  parameter int unsigned LVL2  = 32,
  parameter int unsigned LVL3  = 56,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  input  logic         q_en,
  input  logic         rx_ie,
  input  logic [1:0]   lvl_sel,
  input  logic         ovr_clr,
  output logic         irq,
  output logic [1:0]   src_code,
  output logic         data_rdy,
  output logic         overrun
);

  logic             mode_q, flush, dropped;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= q_en;
  end
  assign flush = (q_en != mode_q);

  rxq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cap_one   (!q_en),
    .push_req  (wr_valid),
    .push_data (wr_data),
    .pop_req   (rd_req),
    .cnt       (cnt),
    .rd_data   (rd_data),
    .dropped   (dropped)
  );

  rxq_trig_eval #(
    .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_mode (q_en),
    .ie         (rx_ie),
    .sel        (lvl_sel),
    .cnt        (cnt),
    .irq        (irq),
    .src        (src_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (dropped) overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  assign data_rdy = (cnt != '0);

  // R3: the overrun flag holds until it is cleared
  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  // R4: an accepted write always leaves data waiting
  p_rdy_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !flush) |=> data_rdy);

  // R12: a mode change empties the store
  p_flush_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_rdy);

endmodule

// File: tb/rxq_trig_buf_tb_top.sv
`timescale 1ns/1ps
module rxq_trig_buf_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, rd_req = 1'b0, ovr_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       q_en = 1'b1, rx_ie = 1'b1;
  logic [1:0] lvl_sel = 2'd0;
  logic [7:0] rd_data;
  logic       irq, data_rdy, overrun;
  logic [1:0] src_code;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxq_trig_buf dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .q_en(q_en), .rx_ie(rx_ie),
    .lvl_sel(lvl_sel), .ovr_clr(ovr_clr), .irq(irq), .src_code(src_code),
    .data_rdy(data_rdy), .overrun(overrun)
  );

  // Fields: wr[24] data[23:16] rd[15] qen[14] ie[13] sel[12:11]
  //         exp_rdy[10] exp_irq[9] chk_rd[8] exp_rd[7:0]
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // idle
    {1'b1, 8'hA1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00}, // R5 lvl 1
    {1'b1, 8'hB2, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 8'hA1}, // R2
    {1'b1, 8'hC3, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 8'hB2}, // R10
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 8'hC3}, // R4 R6
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 8'hC3}, // R9
    {1'b1, 8'h44, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00}, // R8
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00}, // R5
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R12
    {1'b1, 8'h55, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00}, // R11
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 8'h55}  // R11
  };

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of strobes, then return just after the next falling edge
  task automatic cyc(bit w, logic [7:0] d, bit r, bit c);
    wr_valid = w; wr_data = d; rd_req = r; ovr_clr = c;
    @(negedge clk);
    wr_valid = 1'b0; rd_req = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic chk_irq(string req, bit exp);
    chk(req, "irq", int'(irq), int'(exp));
    chk("R7", "src_code", int'(src_code), exp ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "data_rdy", int'(data_rdy), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "src_code", int'(src_code), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rd_data after reset", int'(rd_data), 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      q_en = v[14]; rx_ie = v[13]; lvl_sel = v[12:11];
      cyc(v[24], v[23:16], v[15], 1'b0);
      chk("R4", $sformatf("vec%0d data_rdy", i), int'(data_rdy), int'(v[10]));
      chk_irq("R5", v[9]);
      if (v[8]) chk("R2", $sformatf("vec%0d rd_data", i), int'(rd_data), int'(v[7:0]));
    end

    // Directed: thresholds, full, overrun
    q_en = 1'b1; rx_ie = 1'b1; lvl_sel = 2'd1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);                 // mode change flushes (R12)
    chk("R12", "data_rdy after flush", int'(data_rdy), 0);
    for (int i = 0; i < 15; i++) cyc(1'b1, 8'(i), 1'b0, 1'b0);
    chk_irq("R5", 1'b0);                          // 15 < 16
    cyc(1'b1, 8'd15, 1'b0, 1'b0);
    chk_irq("R5", 1'b1);                          // 16 reached
    lvl_sel = 2'd2; #0.5;
    chk_irq("R5", 1'b0);                          // 16 < 32
    lvl_sel = 2'd0; #0.5;
    chk_irq("R5", 1'b1);
    lvl_sel = 2'd3;
    for (int i = 16; i < 55; i++) cyc(1'b1, 8'(i), 1'b0, 1'b0);
    chk_irq("R5", 1'b0);                          // 55 < 56
    cyc(1'b1, 8'd55, 1'b0, 1'b0);
    chk_irq("R5", 1'b1);                          // 56
    cyc(1'b0, 8'h00, 1'b1, 1'b0);                 // pop 0 -> 55
    chk("R2", "first pop", int'(rd_data), 0);
    chk_irq("R6", 1'b0);
    for (int i = 56; i < 65; i++) cyc(1'b1, 8'(i), 1'b0, 1'b0);
    chk_irq("R5", 1'b1);                          // 64 held: 1..64
    cyc(1'b1, 8'hAA, 1'b0, 1'b0);                 // discarded
    chk("R3", "overrun on full write", int'(overrun), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R3", "overrun sticky", int'(overrun), 1);
    cyc(1'b1, 8'd65, 1'b1, 1'b0);                 // push+pop when full
    chk("R10", "pop during full push", int'(rd_data), 1);
    chk("R3", "overrun kept", int'(overrun), 1);
    cyc(1'b1, 8'hBB, 1'b0, 1'b1);                 // loss and clear together
    chk("R3", "loss beats clear", int'(overrun), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R3", "overrun cleared", int'(overrun), 0);
    for (int i = 2; i <= 65; i++) begin
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R2", $sformatf("drain %0d", i), int'(rd_data), i);
      if (i == 10) chk_irq("R6", 1'b0);
    end
    chk("R4", "data_rdy after drain", int'(data_rdy), 0);
    chk_irq("R5", 1'b0);

    // Holding register mode
    q_en = 1'b0;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 8'h11, 1'b0, 1'b0);
    chk_irq("R11", 1'b1);
    cyc(1'b1, 8'h22, 1'b0, 1'b0);
    chk("R11", "second write overrun", int'(overrun), 1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R11", "held byte", int'(rd_data), 8'h11);
    chk("R11", "data_rdy after read", int'(data_rdy), 0);
    chk_irq("R11", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule